// File: doc/BRIEF.md
# Floating-Point to Logarithmic Converter

This block turns one floating-point word (sign, biased exponent, fraction with a hidden leading one) into a signed logarithmic word. The output has a two-bit class field, the sign, a two's-complement integer part and a fixed-point fractional part. The integer part is the unbiased exponent. The fractional part is log2 of the mantissa 1.f. Special input encodings are classified separately, and the sign is passed straight through.

The fractional logarithm comes from multiplicative normalization, one bit per cycle. A running product p starts at 1.0. At step i the trial value p·(1+2^-i) is formed with a shift and an add. If the trial does not exceed 1.f, p takes the trial value and the constant log2(1+2^-i) is added to an accumulator. The constants are derived at elaboration time from the fraction width, so no lookup memory is used.

A caller asserts `start` for one cycle while the block is idle. Exactly FW cycles later `done` pulses for one cycle. The result then stays on the outputs until the next accepted start.

Top module: `fp2lns_conv`

## Requirements
- R1: The output sign equals bit EW+FW (the top bit) of the word sampled at the accepted start, for every input class.
- R2: An input with exponent field 0 and fraction 0 gives class code 2'b00 (zero), with integer and fraction outputs both 0.
- R3: An input with an all-ones exponent and fraction 0 gives class code 2'b10 (infinity), with integer and fraction outputs 0.
- R4: An input with an all-ones exponent and a nonzero fraction gives class code 2'b11 (not-a-number), with integer and fraction outputs 0.
- R5: An input with exponent field 0 and a nonzero fraction (denormal) is flushed: class code 2'b00, integer and fraction outputs 0.
- R6: Any other input gives class code 2'b01 (normal). The integer output is the exponent field minus 2^(EW-1)-1, as an EW-bit two's-complement value.
- R7: For a normal input, the fraction output differs from 2^FW·log2(1 + f/2^FW) by at most FW+2 units, and it is exactly 0 when f is 0.
- R8: `busy` rises on the clock edge that samples `start` while idle. `done` is high for exactly one cycle, FW edges after that start edge, and `busy` falls on the same edge.
- R9: `start` asserted while `busy` is high has no effect: the timing and the result of the conversion in progress are unchanged.
- R10: After `done`, all result outputs hold their values until the next accepted start, whatever `fp_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion of `fp_in` (accepted only when idle) |
| fp_in | input | 1+EW+FW | Floating-point word: sign, exponent, fraction |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| lns_class | output | 2 | 00 zero, 01 normal, 10 infinity, 11 not-a-number |
| lns_sign | output | 1 | Sign of the value |
| lns_int | output | EW | Two's-complement integer part of the logarithm |
| lns_frac | output | FW | Fractional part of the logarithm |

## Verification
The bench builds the converter with a 6-bit exponent and a 12-bit fraction. At that size all 4096 mantissas can be swept exhaustively, so every accept-or-reject pattern of the factor loop occurs. Each result is compared against a real-valued logarithm. The sweep also walks the exponent across its whole normal range, from the most negative to the most positive integer output, and pairs that with the reserved exponent codes. With the fraction this short, a busy-time start and a hold test cost only a few cycles each.

// File: rtl/fp2lns_conv.sv
module fp2lns_conv #(
  parameter int EW = 8,
  parameter int FW = 23,
  parameter int GW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [EW+FW:0]       fp_in,
  output logic                 busy,
  output logic                 done,
  output logic [1:0]           lns_class,
  output logic                 lns_sign,
  output logic [EW-1:0]        lns_int,
  output logic [FW-1:0]        lns_frac
);
  localparam int TW = FW + GW;
  localparam int PW = TW + 2;
  localparam int CW = $clog2(FW + 1);
  localparam logic [EW-1:0] BIAS = {1'b0, {(EW-1){1'b1}}};
  localparam logic [PW-1:0] ONE  = PW'(1) << TW;
  localparam logic [1:0] C_ZERO = 2'b00, C_NORM = 2'b01, C_INF = 2'b10, C_NAN = 2'b11;

  function automatic logic [FW-1:0] log_term(input int i);
    logic [127:0] x;
    logic [FW-1:0] r;
    x = (128'd1 << 60) + (128'd1 << (60 - i));
    r = '0;
    for (int b = FW - 1; b >= 0; b--) begin
      x = (x * x) >> 60;
      if (x >= (128'd1 << 61)) begin
        r[b] = 1'b1;
        x = x >> 1;
      end
    end
    return r;
  endfunction

  logic [FW-1:0] ltab [0:FW];
  assign ltab[0] = '0;
  for (genvar g = 1; g <= FW; g++) begin : g_tab
    assign ltab[g] = log_term(g);
  end

  logic [EW-1:0] e_f;
  logic [FW-1:0] f_f;
  logic [1:0]    cls_in;
  assign e_f = fp_in[FW +: EW];
  assign f_f = fp_in[FW-1:0];
  assign cls_in = (e_f == '0)  ? C_ZERO :
                  (&e_f)       ? ((f_f == '0) ? C_INF : C_NAN) :
                                 C_NORM;

  logic [CW-1:0] idx;
  logic [PW-1:0] p, tgt, trial;
  logic [FW-1:0] acc;
  logic [1:0]    cls;
  logic          sgn;
  logic [EW-1:0] ival;

  assign trial = p + (p >> idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      idx  <= '0;
      p    <= '0;
      tgt  <= '0;
      acc  <= '0;
      cls  <= C_ZERO;
      sgn  <= 1'b0;
      ival <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy <= 1'b1;
        idx  <= CW'(1);
        p    <= ONE;
        tgt  <= {2'b01, f_f, {GW{1'b0}}};
        acc  <= '0;
        cls  <= cls_in;
        sgn  <= fp_in[EW+FW];
        ival <= e_f - BIAS;
      end else if (busy) begin
        if (trial <= tgt) begin
          p   <= trial;
          acc <= acc + ltab[idx];
        end
        if (idx == CW'(FW)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + CW'(1);
        end
      end
    end
  end

  assign lns_class = cls;
  assign lns_sign  = sgn;
  assign lns_int   = (cls == C_NORM) ? ival : '0;
  assign lns_frac  = (cls == C_NORM) ? acc  : '0;

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  a_r8_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r9_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx != CW'(FW)) |=> busy);
  a_r7_product_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (p <= tgt));
  a_r7_sum_grows: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (acc >= $past(acc)));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(acc) && $stable(cls) && $stable(ival) && $stable(sgn)));
endmodule

// File: tb/fp2lns_conv_test.sv
module fp2lns_conv_test;
  localparam int EW = 6;
  localparam int FW = 12;
  localparam int WW = 1 + EW + FW;
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int EMAX = (1 << EW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [WW-1:0] fp_in = '0;
  logic busy, done, lns_sign;
  logic [1:0] lns_class;
  logic [EW-1:0] lns_int;
  logic [FW-1:0] lns_frac;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  fp2lns_conv #(.EW(EW), .FW(FW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .fp_in(fp_in),
    .busy(busy), .done(done), .lns_class(lns_class), .lns_sign(lns_sign),
    .lns_int(lns_int), .lns_frac(lns_frac));

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // cycle-level handshake model (R8, R9)
  bit m_busy = 1'b0, m_done = 1'b0;
  int m_cnt = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_cnt <= 0;
    end else begin
      m_done <= 1'b0;
      if (!m_busy && start) begin
        m_busy <= 1'b1; m_cnt <= FW;
      end else if (m_busy) begin
        if (m_cnt == 1) begin m_busy <= 1'b0; m_done <= 1'b1; end
        m_cnt <= m_cnt - 1;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(busy == m_busy, "R8 busy", busy, m_busy);
    chk(done == m_done, "R8 done", done, m_done);
  end

  task automatic check_result(input bit s, input int e, input int f);
    int ecls, eint;
    real ref_v;
    chk(lns_sign == s, "R1 sign", lns_sign, s);
    if (e == 0 && f == 0) ecls = 0;
    else if (e == 0) ecls = 0;
    else if (e == EMAX) ecls = (f == 0) ? 2 : 3;
    else ecls = 1;
    if (e == 0) chk(lns_class == 2'(ecls), (f == 0) ? "R2 class" : "R5 class", lns_class, ecls);
    else if (e == EMAX) chk(lns_class == 2'(ecls), (f == 0) ? "R3 class" : "R4 class", lns_class, ecls);
    else chk(lns_class == 2'(ecls), "R6 class", lns_class, ecls);
    if (ecls != 1) begin
      chk(lns_int == '0 && lns_frac == '0, "R2 R3 R4 R5 zero payload", {lns_int, lns_frac}, 0);
    end else begin
      eint = (e - BIAS) & ((1 << EW) - 1);
      chk(int'(lns_int) == eint, "R6 integer", lns_int, eint);
      ref_v = $ln(1.0 + real'(f) / real'(1 << FW)) / $ln(2.0) * real'(1 << FW);
      if (f == 0) chk(lns_frac == '0, "R7 exact zero", lns_frac, 0);
      else chk((real'(lns_frac) - ref_v <= real'(FW + 2)) && (ref_v - real'(lns_frac) <= real'(FW + 2)),
               "R7 fraction", lns_frac, longint'(ref_v));
    end
  endtask

  task automatic convert(input bit s, input int e, input int f);
    @(negedge clk);
    fp_in = {s, e[EW-1:0], f[FW-1:0]};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check_result(s, e, f);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R8 reset idle", {busy, done}, 0);
    chk(lns_class == 2'b00 && lns_int == '0 && lns_frac == '0, "R2 reset outputs",
        {lns_class, lns_int, lns_frac}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    convert(1'b0, 0, 0);
    convert(1'b1, 0, 0);
    convert(1'b0, EMAX, 0);
    convert(1'b1, EMAX, 0);
    convert(1'b0, EMAX, 1);
    convert(1'b1, EMAX, (1 << FW) - 1);
    convert(1'b0, 0, 5);
    convert(1'b1, 0, (1 << FW) - 1);
    convert(1'b0, 1, 0);
    convert(1'b0, EMAX - 1, (1 << FW) - 1);
    convert(1'b1, BIAS, 1 << (FW - 1));

    for (int f = 0; f < (1 << FW); f++)
      convert(f[0], 1 + (f % (EMAX - 1)), f);

    // R9: start during a conversion is ignored
    @(negedge clk);
    fp_in = {1'b0, 6'(BIAS + 3), 12'd1234};
    start = 1'b1;
    @(negedge clk);
    fp_in = {1'b1, 6'(EMAX), 12'd7};
    repeat (3) @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check_result(1'b0, BIAS + 3, 1234);
    chk(lns_class == 2'b01, "R9 ignored start class", lns_class, 1);

    // R10: outputs hold after done
    fp_in = {1'b1, 6'(EMAX), 12'd99};
    repeat (6) @(negedge clk);
    check_result(1'b0, BIAS + 3, 1234);
    chk(busy == 1'b0, "R10 stays idle", busy, 0);

    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule